// File: doc/BRIEF.md
# Card Clock Ratio Divider

This block derives the clock sent to a contact smart card from a reference clock of up to 20 MHz. A two-bit select chooses one of four ratios (divide by 1, 2, 4 or 8). The selected ratio may be changed while the card clock is running. The switch is made at a point where every candidate waveform begins a fresh low phase, so the card never sees a truncated or stretched pulse.

A session sequencer supplies an enable. While the enable is low the card clock is parked low. When the enable rises, the first pulse is a complete one for the selected ratio. Divide by 1 does not go through the counter. The reference clock itself is gated through a falling-edge-controlled gate, and it never overlaps with the counter-derived path.

The select lines are treated as asynchronous and pass through a two-stage synchronizer. The enable is taken as synchronous to the reference clock.

Top module: `cardclk_div`

## Requirements
- R1: The select code sets the output period. 2'b00 gives 8, 2'b01 gives 4, 2'b11 gives 2 and 2'b10 gives 1 reference periods.
- R2: For ratio N, the output is high for exactly N/2 reference periods per cycle. For ratio 1 the output follows the high phase of the reference clock.
- R3: Across any ratio change, no high or low phase of the output is shorter than half a reference period. The last pulse of the old ratio and the first pulse of the new ratio both have full width.
- R4: The select passes through a two-stage synchronizer. The change to a new ratio occurs only at a clock edge where the low-order counter bits covering both the old and new ratios are all ones, and the output falls there. A changed synchronized select is adopted within 8 reference cycles. Any high pulse that starts more than 12 reference cycles after the select change has the new width.
- R5: With the enable low, the output is held low from the second reference cycle onward.
- R6: When the enable rises, the output first spends a full low half-period of the selected ratio. Its first high pulse then has full width.
- R7: A select change made while the enable is low is adopted without waiting. The first pulse after the enable rises uses the new ratio.
- R8: While reset is asserted, and afterwards until the enable rises, the output is low. The ratio after reset is divide by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, up to 20 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Card clock enable from the session sequencer, synchronous to ref_clk |
| ratio_sel | input | 2 | Ratio select code; may change asynchronously, one bit at a time |
| card_clk | output | 1 | Clock driven to the card |

## Verification
The assertions check the following on every reference edge:
- the gated divide-by-1 path and the counter path are never on together;
- every counter-path high phase is exactly the half-period of the ratio it started under, and every low phase is at least as long;
- the active ratio changes only on a shared phase boundary, and never waits more than eight cycles;
- the output stays quiet while the enable has been low.

Only the bench scenarios can show the things that need measured time at the pin:
- that the decoded periods match the select codes;
- that divide-by-1 pulses and the pulses around a change keep their width;
- that a change made while disabled takes effect at the very first pulse.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;

  typedef logic [1:0] ratio_code_t;
  typedef logic [1:0] ratio_log_t;

  localparam int unsigned LOG_MAX = 3;
  localparam int unsigned CNT_W   = LOG_MAX;

  localparam ratio_code_t CODE_DIV8 = 2'b00;
  localparam ratio_code_t CODE_DIV4 = 2'b01;
  localparam ratio_code_t CODE_DIV2 = 2'b11;
  localparam ratio_code_t CODE_DIV1 = 2'b10;

  localparam ratio_log_t LOG_DIV8 = 2'd3;

  // Neighbouring ratios differ in one code bit.
  function automatic ratio_log_t code_to_log(input ratio_code_t code);
    ratio_log_t lg;
    case (code)
      CODE_DIV8: lg = 2'd3;
      CODE_DIV4: lg = 2'd2;
      CODE_DIV2: lg = 2'd1;
      default:   lg = 2'd0;
    endcase
    return lg;
  endfunction

  function automatic ratio_log_t log_max(input ratio_log_t a, input ratio_log_t b);
    return (a > b) ? a : b;
  endfunction

  // Reference cycles in one phase of the counter path.
  function automatic int unsigned half_cycles(input ratio_log_t lg);
    return (lg == 2'd0) ? 32'd0 : (32'd1 << (lg - 2'd1));
  endfunction

endpackage

// File: rtl/cardclk_sync.sv
`timescale 1ns/1ps
module cardclk_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cardclk_phase_cnt.sv
`timescale 1ns/1ps
module cardclk_phase_cnt
  import cardclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);

  // Parked at all ones while stopped, so the first running edge wraps
  // to zero and every tap starts a fresh low phase.
  always_comb cnt_next = run ? cnt_q + 1'b1 : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_next;
  end

endmodule

// File: rtl/cardclk_ratio_ctl.sv
`timescale 1ns/1ps
module cardclk_ratio_ctl
  import cardclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ratio_code_t      sel_code,
  input  logic [CNT_W-1:0] cnt_q,
  output ratio_log_t       act_lg,
  output ratio_log_t       act_next
);

  ratio_log_t       want_lg;
  ratio_log_t       span_lg;
  logic [CNT_W-1:0] span_mask;
  logic             edge_ok;
  logic             swap_evt;

  always_comb begin
    want_lg   = code_to_log(sel_code);
    span_lg   = log_max(want_lg, act_lg);
    span_mask = CNT_W'((32'd1 << span_lg) - 32'd1);
    edge_ok   = (cnt_q & span_mask) == span_mask;
    swap_evt  = (want_lg != act_lg) && edge_ok;
    act_next  = swap_evt ? want_lg : act_lg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_lg <= LOG_DIV8;
    else        act_lg <= act_next;
  end

  // Cycles spent with a stable, not yet adopted request.
  ratio_log_t     want_q;
  logic [CNT_W:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q    <= LOG_DIV8;
      stall_cnt <= '0;
    end else begin
      want_q <= want_lg;
      if (want_lg != act_lg && want_lg == want_q)
        stall_cnt <= (stall_cnt == '1) ? stall_cnt : stall_cnt + 1'b1;
      else
        stall_cnt <= '0;
    end
  end

  assert_swap_on_boundary_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(act_lg) |-> $past(edge_ok)
  ) else $error("ratio changed off a shared phase boundary");

  assert_swap_latency_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    32'(stall_cnt) <= (32'd1 << CNT_W)
  ) else $error("ratio request waited too long");

endmodule

// File: rtl/cardclk_out_stage.sv
`timescale 1ns/1ps
module cardclk_out_stage
  import cardclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  ratio_log_t       act_lg,
  input  ratio_log_t       act_next,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             card_clk
);

  localparam int unsigned RUN_W = CNT_W + 1;

  function automatic logic tap(input logic [CNT_W-1:0] c, input ratio_log_t lg);
    logic b;
    b = 1'b0;
    for (int i = 1; i <= int'(CNT_W); i++)
      if (int'(lg) == i) b = c[i-1];
    return b;
  endfunction

  logic en_q;
  logic div_q;
  logic div_d;
  logic gate_q;

  always_comb div_d = en && tap(cnt_next, act_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
    end else begin
      en_q  <= en;
      div_q <= div_d;
    end
  end

  // Opened or closed only while the reference clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_q && (act_lg == 2'd0);
  end

  assign card_clk = (clk & gate_q) | div_q;

  // Length of the current level of the counter path.
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_len <= '1;
    else if (div_d != div_q)  run_len <= RUN_W'(1);
    else if (run_len != '1)   run_len <= run_len + 1'b1;
  end

  assert_paths_exclusive_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(gate_q && div_q)
  ) else $error("gated and divided paths on together");

  assert_high_run_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    ($fell(div_q) && en_q) |-> (32'($past(run_len)) == half_cycles($past(act_lg)))
  ) else $error("high phase width wrong");

  assert_low_run_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> (32'($past(run_len)) >= half_cycles(act_lg))
  ) else $error("low phase too short");

  assert_quiet_off_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> (!div_q && !gate_q)
  ) else $error("output active while disabled");

endmodule

// File: rtl/cardclk_div.sv
`timescale 1ns/1ps
module cardclk_div
  import cardclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic [1:0] ratio_sel,
  output logic       card_clk
);

  ratio_code_t      sel_sync;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  ratio_log_t       act_lg;
  ratio_log_t       act_next;

  cardclk_sync #(
    .WIDTH  ($bits(ratio_code_t)),
    .STAGES (SYNC_STAGES)
  ) u_sel_sync (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .async_in (ratio_sel),
    .sync_out (sel_sync)
  );

  cardclk_phase_cnt u_cnt (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .run      (clk_en),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next)
  );

  cardclk_ratio_ctl u_ctl (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .sel_code (sel_sync),
    .cnt_q    (cnt_q),
    .act_lg   (act_lg),
    .act_next (act_next)
  );

  cardclk_out_stage u_out (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .en       (clk_en),
    .act_lg   (act_lg),
    .act_next (act_next),
    .cnt_next (cnt_next),
    .card_clk (card_clk)
  );

endmodule

// File: tb/cardclk_div_bench.sv
`timescale 1ns/1ps
module cardclk_div_bench;

  localparam realtime TCK = 8.0;

  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       clk_en  = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic       card_clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 ref_clk = ~ref_clk;

  cardclk_div u_cardclk_div (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .ratio_sel (ratio_sel),
    .card_clk  (card_clk)
  );

  // Scoreboard queues: one expected pulse per entry.
  realtime q_after[$];
  realtime q_high[$];
  realtime q_per[$];
  string   q_tag[$];

  task automatic check_val(input string req, input string what,
                           input real act, input real exp);
    n_chk++;
    if (act > exp + 0.01 || act < exp - 0.01) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor.
  realtime last_rise = 0.0;
  realtime last_fall = 0.0;
  realtime min_w     = 1.0e9;
  bit      have_rise = 1'b0;
  bit      have_fall = 1'b0;
  bit      pend_per  = 1'b0;

  always @(posedge card_clk) begin
    realtime t;
    t = $realtime;
    if (have_fall && (t - last_fall) < min_w) min_w = t - last_fall;
    if (pend_per) begin
      check_val(q_tag[0], "period", t - last_rise, q_per[0]);
      pend_per = 1'b0;
      void'(q_after.pop_front());
      void'(q_high.pop_front());
      void'(q_per.pop_front());
      void'(q_tag.pop_front());
    end
    last_rise = t;
    have_rise = 1'b1;
  end

  always @(negedge card_clk) begin
    realtime t;
    t = $realtime;
    if (have_rise) begin
      if ((t - last_rise) < min_w) min_w = t - last_rise;
      if (q_after.size() > 0 && !pend_per && last_rise >= q_after[0]) begin
        check_val(q_tag[0], "high width", t - last_rise, q_high[0]);
        pend_per = 1'b1;
      end
    end
    last_fall = t;
    have_fall = 1'b1;
  end

  // Driver side.
  task automatic push_exp(input realtime after, input int div, input string tag);
    q_after.push_back(after);
    q_high.push_back(4.0 * div);
    q_per.push_back(TCK * div);
    q_tag.push_back(tag);
  endtask

  task automatic drain;
    while (q_after.size() != 0) @(posedge ref_clk);
  endtask

  task automatic expect_ratio(input logic [1:0] code, input int div, input string tag);
    realtime t0;
    @(negedge ref_clk); #1;
    ratio_sel = code;
    t0 = $realtime;
    push_exp(t0 + 12.0 * TCK, div, tag);
    drain();
  endtask

  task automatic expect_quiet(input string req, input int halves);
    int bad;
    bad = 0;
    for (int i = 0; i < halves; i++) begin
      @(ref_clk); #2;
      if (card_clk !== 1'b0) bad++;
    end
    check_val(req, "high samples while quiet", real'(bad), 0.0);
  endtask

  initial begin
    realtime t_en;
    repeat (5) @(posedge ref_clk);
    #2;
    check_val("R8", "output in reset", real'(card_clk), 0.0);
    @(negedge ref_clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge ref_clk);
    expect_quiet("R8", 20);

    // Enable with default ratio (divide by 8): clean first pulse.
    @(negedge ref_clk); #1;
    clk_en = 1'b1;
    t_en = $realtime;
    push_exp(t_en, 8, "R6");
    drain();

    // Ratio walk, one code bit at a time.
    expect_ratio(2'b01, 4, "R1");
    expect_ratio(2'b11, 2, "R1");
    expect_ratio(2'b10, 1, "R1");
    expect_ratio(2'b11, 2, "R4");
    expect_ratio(2'b01, 4, "R4");
    expect_ratio(2'b00, 8, "R2");
    expect_ratio(2'b10, 1, "R2");
    expect_ratio(2'b00, 8, "R3");
    expect_ratio(2'b01, 4, "R3");

    // Disable while dividing by 4.
    @(negedge ref_clk); #1;
    clk_en = 1'b0;
    repeat (2) @(posedge ref_clk);
    expect_quiet("R5", 32);

    // Change ratio while disabled, then enable.
    @(negedge ref_clk); #1;
    ratio_sel = 2'b11;
    repeat (4) @(posedge ref_clk);
    expect_quiet("R5", 8);
    @(negedge ref_clk); #1;
    clk_en = 1'b1;
    t_en = $realtime;
    push_exp(t_en, 2, "R7");
    drain();

    // Shortest phase seen over the whole run (45% of a reference period).
    n_chk++;
    if (min_w < 0.45 * TCK) begin
      n_fail++;
      $display("FAIL R3 shortest phase: actual %0.3f expected >= %0.3f", min_w, 0.45 * TCK);
    end

    repeat (4) @(posedge ref_clk);
    finish_run();
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule